// File: doc/BRIEF.md
# Core and DMA Bus Ownership Arbiter

This block decides, cycle by cycle, who owns an internal bus shared by one processor core and a DMA module with four channels. The DMA side is first reduced to one candidate: among the channels that are requesting, the one with the smallest 3-bit priority code wins, and when codes are equal the lower channel number wins. That single candidate then competes with the core in a two-party round robin in which the core holds the first turn after reset.

Ownership is registered. A new owner is chosen only when the bus is idle (no grant held) or in the cycle where the current owner signals the end of its transfer. Otherwise the current owner keeps the grant. The grant is a five-position one-hot vector, and a separate output gives the number of the channel that was granted. A 2-bit park mode input is accepted, but every value of it selects the same round-robin behaviour.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `grant` is all zeros and `grant_chan` is 0. The first contested decision after reset goes to the core.
- R2: `grant` bit 0 means the core owns the bus, and bit 1+i means DMA channel i owns it. At most one bit is set at any time.
- R3: Among the DMA channels that are requesting, the one with the numerically smallest priority code (`dma_prio` bits [3i+2:3i] for channel i) is the DMA candidate.
- R4: When several requesting channels share the smallest code, the lowest-numbered of them is the DMA candidate.
- R5: At a decision point where the core and at least one DMA channel are requesting, the grant goes to whichever party did not receive the previous non-empty grant.
- R6: At a decision point where only one party is requesting, that party receives the grant whatever the turn state is.
- R7: A decision point is a cycle in which `grant` is all zeros or `xfer_done` is high. In any other cycle, `grant` keeps its value. The result of a decision appears on `grant` one clock later.
- R8: At a decision point with no requests, `grant` becomes all zeros and the turn state does not change.
- R9: If the core requests while a DMA transfer is finishing, the next grant goes to the core, even when other DMA channels are waiting.
- R10: `park_mode` has no effect on grants; all four values behave as the round robin.
- R11: `grant_chan` carries the index of the granted DMA channel, and is 0 when the core or nobody holds the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core requests the bus |
| dma_req | input | NUM_CH | Per-channel DMA requests |
| dma_prio | input | NUM_CH*PRIO_W | Per-channel priority codes, channel i at bits [PRIO_W*i +: PRIO_W] |
| park_mode | input | 2 | Arbitration mode field; every value acts as round robin |
| xfer_done | input | 1 | Current owner finishes its transfer this cycle |
| grant | output | NUM_CH+1 | One-hot owner: bit 0 core, bit 1+i channel i |
| grant_chan | output | CH_W | Index of the granted DMA channel |

## Verification
Contested sequences, with the core and DMA channels requesting together, show whether the turn really alternates and whether the core takes priority after reset. One of them keeps a second DMA channel waiting, which shows that the core is served before that channel. Patterns with only the core or only DMA requesting, and patterns that let the bus go idle, show that a sole requester ignores the turn and that an empty decision leaves the turn unchanged. DMA-only patterns with mixed codes, equal codes, and a higher-numbered channel holding the best code separate the ordering by code from the ordering by channel number. The same contested sequence is repeated under non-zero park modes to show that the mode has no effect.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Which party the round robin favours at the next contested decision.
  typedef enum logic {
    TURN_CORE = 1'b0,
    TURN_DMA  = 1'b1
  } turn_e;

  // Position of the core inside the one-hot grant vector.
  localparam int unsigned CORE_SLOT = 0;

endpackage

// File: rtl/dma_channel_picker.sv
module dma_channel_picker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  output logic [NUM_CH-1:0]        win,
  output logic                     any,
  output logic [CH_W-1:0]          win_idx
);

  // beats[i][j]: channel i is preferred over channel j (or j is silent)
  logic [NUM_CH-1:0] beats [NUM_CH];

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_row
    for (genvar gj = 0; gj < NUM_CH; gj++) begin : g_col
      if (gi == gj) begin : g_self
        assign beats[gi][gj] = 1'b1;
      end else if (gi < gj) begin : g_lower
        // lower-numbered channel also wins on an equal code
        assign beats[gi][gj] = !req[gj] ||
          (prio[gi*PRIO_W +: PRIO_W] <= prio[gj*PRIO_W +: PRIO_W]);
      end else begin : g_higher
        assign beats[gi][gj] = !req[gj] ||
          (prio[gi*PRIO_W +: PRIO_W] <  prio[gj*PRIO_W +: PRIO_W]);
      end
    end
    assign win[gi] = req[gi] & (&beats[gi]);
  end

  assign any = |req;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (win[i]) win_idx = CH_W'(i);
    end
  end

  // R3/R4: exactly one winner whenever any channel asks, none otherwise
  always_comb begin
    assert_single_winner_R4: assert ($onehot0(win))
      else $error("picker produced several winners");
    assert_winner_present_R3: assert ((|win) == any)
      else $error("picker winner presence mismatch");
  end

endmodule

// File: rtl/rr_turn_tracker.sv
module rr_turn_tracker
  import bus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] park_mode,
  input  logic       decide,
  input  logic       core_req,
  input  logic       dma_any,
  output logic       pick_core,
  output logic       pick_dma
);

  turn_e turn_q;
  logic  rr_enable;

  // Every park mode folds onto the alternating policy.
  always_comb begin
    case (park_mode)
      2'b00:   rr_enable = 1'b1;
      default: rr_enable = 1'b1;
    endcase
  end

  always_comb begin
    pick_core = 1'b0;
    pick_dma  = 1'b0;
    if (core_req && dma_any) begin
      if (!rr_enable || turn_q == TURN_CORE) pick_core = 1'b1;
      else                                   pick_dma  = 1'b1;
    end else if (core_req) begin
      pick_core = 1'b1;
    end else if (dma_any) begin
      pick_dma = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn_q <= TURN_CORE;
    end else if (decide) begin
      if (pick_core)     turn_q <= TURN_DMA;
      else if (pick_dma) turn_q <= TURN_CORE;
    end
  end

  // R8: a decision with nobody asking leaves the turn alone
  assert_turn_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (decide && !core_req && !dma_any) |=> $stable(turn_q))
    else $error("turn moved on an empty decision");

  // R6: a lone requester is picked
  assert_lone_core_R6: assert property (@(posedge clk) disable iff (rst)
    (core_req && !dma_any) |-> (pick_core && !pick_dma))
    else $error("lone core request not picked");

endmodule

// File: rtl/grant_hold_reg.sv
module grant_hold_reg #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned G_W   = NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              pick_core,
  input  logic              pick_dma,
  input  logic [NUM_CH-1:0] dma_win,
  input  logic [CH_W-1:0]   dma_idx,
  output logic [G_W-1:0]    grant_q,
  output logic [CH_W-1:0]   chan_q
);

  logic [G_W-1:0]  grant_d;
  logic [CH_W-1:0] chan_d;

  always_comb begin
    grant_d = {(pick_dma ? dma_win : {NUM_CH{1'b0}}), pick_core};
    chan_d  = pick_dma ? dma_idx : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      chan_q  <= '0;
    end else if (load) begin
      grant_q <= grant_d;
      chan_q  <= chan_d;
    end
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q))
    else $error("more than one grant asserted");

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(grant_q))
    else $error("grant changed outside a decision");

  assert_chan_matches_R11: assert property (@(posedge clk) disable iff (rst)
    (grant_q[0] || grant_q == '0) |-> (chan_q == '0))
    else $error("channel index not zero without a DMA grant");

endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
  import bus_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned G_W   = NUM_CH + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     core_req,
  input  logic [NUM_CH-1:0]        dma_req,
  input  logic [NUM_CH*PRIO_W-1:0] dma_prio,
  input  logic [1:0]               park_mode,
  input  logic                     xfer_done,
  output logic [G_W-1:0]           grant,
  output logic [CH_W-1:0]          grant_chan
);

  logic [NUM_CH-1:0] dma_win;
  logic              dma_any;
  logic [CH_W-1:0]   dma_idx;
  logic              pick_core;
  logic              pick_dma;
  logic              decide;
  logic [G_W-1:0]    grant_q;
  logic [CH_W-1:0]   chan_q;

  // A decision happens on an idle bus or when the owner finishes.
  assign decide = (grant_q == '0) || xfer_done;

  dma_channel_picker #(
    .NUM_CH (NUM_CH),
    .PRIO_W (PRIO_W)
  ) u_picker (
    .req     (dma_req),
    .prio    (dma_prio),
    .win     (dma_win),
    .any     (dma_any),
    .win_idx (dma_idx)
  );

  rr_turn_tracker u_turn (
    .clk       (clk),
    .rst       (rst),
    .park_mode (park_mode),
    .decide    (decide),
    .core_req  (core_req),
    .dma_any   (dma_any),
    .pick_core (pick_core),
    .pick_dma  (pick_dma)
  );

  grant_hold_reg #(
    .NUM_CH (NUM_CH)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (decide),
    .pick_core (pick_core),
    .pick_dma  (pick_dma),
    .dma_win   (dma_win),
    .dma_idx   (dma_idx),
    .grant_q   (grant_q),
    .chan_q    (chan_q)
  );

  assign grant      = grant_q;
  assign grant_chan = chan_q;

  // R9: DMA finishing while the core waits hands the bus to the core
  assert_core_after_dma_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && (|grant_q[G_W-1:1]) && core_req) |=> grant_q[CORE_SLOT])
    else $error("core not served after DMA transfer");

  // R5: contested decision after a core grant goes to DMA
  assert_alternate_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && grant_q[CORE_SLOT] && core_req && (|dma_req))
      |=> (|grant_q[G_W-1:1]))
    else $error("contested decision did not alternate");

  // R8: nobody asking at a decision clears the grant
  assert_empty_decision_R8: assert property (@(posedge clk) disable iff (rst)
    (decide && !core_req && !(|dma_req)) |=> (grant_q == '0))
    else $error("grant held with no requesters");

endmodule

// File: tb/bus_owner_arbiter_bench.sv
module bus_owner_arbiter_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [4:0] g;
    logic [1:0] c;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_req = 1'b0;
  logic [3:0]  dma_req = '0;
  logic [11:0] dma_prio = '0;
  logic [1:0]  park_mode = '0;
  logic        xfer_done = 1'b0;
  logic [4:0]  grant;
  logic [1:0]  grant_chan;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done_flag = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_arbiter u_bus_owner_arbiter (
    .clk        (clk),
    .rst        (rst),
    .core_req   (core_req),
    .dma_req    (dma_req),
    .dma_prio   (dma_prio),
    .park_mode  (park_mode),
    .xfer_done  (xfer_done),
    .grant      (grant),
    .grant_chan (grant_chan)
  );

  function automatic logic [11:0] pr(input int p0, input int p1, input int p2, input int p3);
    return {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
  endfunction

  task automatic check(input logic [4:0] eg, input logic [1:0] ec, input string tag);
    n_checks++;
    if (grant !== eg || grant_chan !== ec) begin
      n_fail++;
      $display("FAIL %s: grant=%b chan=%0d expected grant=%b chan=%0d",
               tag, grant, grant_chan, eg, ec);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the outcome it should cause
  task automatic step(input logic c, input logic [3:0] r, input logic [11:0] p,
                      input logic [1:0] pk, input logic d,
                      input logic [4:0] eg, input logic [1:0] ec, input string tag);
    exp_t e;
    @(negedge clk);
    core_req  = c;
    dma_req   = r;
    dma_prio  = p;
    park_mode = pk;
    xfer_done = d;
    e.g = eg; e.c = ec; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare after each edge that consumes a queued item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.g, e.c, e.tag);
      end
    end
  end

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(5'b00000, 2'd0, "R1 reset held");
    rst = 1'b0;
    #1;
    check(5'b00000, 2'd0, "R1 after release");

    // contested start: core first, then alternation
    step(1, 4'b0011, pr(2,2,0,0), 2'b00, 0, 5'b00001, 2'd0, "R1 R5 core first");
    step(1, 4'b0011, pr(2,2,0,0), 2'b00, 0, 5'b00001, 2'd0, "R7 hold during transfer");
    step(1, 4'b0011, pr(2,2,0,0), 2'b00, 1, 5'b00010, 2'd0, "R4 R5 equal codes ch0");
    step(1, 4'b0011, pr(2,2,0,0), 2'b00, 1, 5'b00001, 2'd0, "R9 core before ch1");
    step(0, 4'b0000, pr(0,0,0,0), 2'b00, 1, 5'b00000, 2'd0, "R8 empty decision");
    step(1, 4'b0000, pr(0,0,0,0), 2'b00, 0, 5'b00001, 2'd0, "R6 lone core off turn");
    step(0, 4'b1000, pr(0,0,0,5), 2'b00, 0, 5'b00001, 2'd0, "R7 owner keeps bus");
    step(0, 4'b1000, pr(0,0,0,5), 2'b00, 1, 5'b10000, 2'd3, "R6 R11 lone ch3");
    step(0, 4'b1110, pr(0,6,1,4), 2'b00, 1, 5'b01000, 2'd2, "R3 lowest code ch2");
    step(0, 4'b1010, pr(0,6,1,4), 2'b00, 1, 5'b10000, 2'd3, "R3 code beats number");
    step(0, 4'b0000, pr(0,0,0,0), 2'b00, 1, 5'b00000, 2'd0, "R8 clear");
    step(1, 4'b0001, pr(7,0,0,0), 2'b00, 0, 5'b00001, 2'd0, "R8 turn unchanged");
    step(1, 4'b0001, pr(7,0,0,0), 2'b00, 1, 5'b00010, 2'd0, "R5 alternate to ch0");
    // park mode variations
    step(1, 4'b0100, pr(0,0,3,0), 2'b11, 1, 5'b00001, 2'd0, "R10 mode 3 core turn");
    step(1, 4'b0100, pr(0,0,3,0), 2'b01, 1, 5'b01000, 2'd2, "R10 mode 1 dma turn");
    step(1, 4'b0000, pr(0,0,0,0), 2'b10, 1, 5'b00001, 2'd0, "R10 R6 mode 2 core");
    step(0, 4'b0000, pr(0,0,0,0), 2'b00, 1, 5'b00000, 2'd0, "R8 idle again");
    // all codes equal
    step(0, 4'b1111, pr(3,3,3,3), 2'b00, 0, 5'b00010, 2'd0, "R4 four equal ch0");
    step(0, 4'b1100, pr(3,3,3,3), 2'b00, 1, 5'b01000, 2'd2, "R4 R11 equal ch2");
    step(0, 4'b0000, pr(0,0,0,0), 2'b00, 1, 5'b00000, 2'd0, "R2 R11 final idle");

    repeat (3) @(posedge clk);
    report();
  end

endmodule